// File: doc/BRIEF.md
# Chained Multi-Channel DMA Engine

The engine moves data from a set of peripheral channels into an internal memory write port with no processor involvement. Each channel holds a current address, a signed-free address step (modifier), a remaining bus-word count, a link pointer and a packing mode. When a channel's peripheral has a 16-bit bus word ready, the engine accepts it. The word is placed into a per-channel accumulator that assembles 16-, 32- or 48-bit internal words. Complete words are written to memory at the current address, and the address then advances by the modifier.

When a channel's count runs out, the engine raises a one-cycle interrupt for that channel. If the link pointer is non-zero, the engine then reads a four-word descriptor from internal memory and reloads the channel, so a list of transfers runs back to back. The lowest-numbered channels are paced by an external device through a request/grant handshake. The other channels take a word on every cycle that their request level is high. When several channels are ready, a fixed priority picks one of them, and one bus word moves per cycle.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, all grants, interrupts, the memory write strobe and the descriptor read strobe are low.
- R2: In each cycle at most one channel is granted, and the grant goes to the ready channel with the lowest index.
- R3: A channel with index PACED_CH or above is granted in every cycle in which it is enabled, its count is non-zero and its request is high.
- R4: A channel with index below PACED_CH is granted once for each rising edge of its request, and the grant lasts one cycle. A rising edge seen while the channel is disabled is held until the channel is enabled. No grant is given while the count is zero.
- R5: Each granted bus word decrements the count by one. Each internal word is written at the current address, and the address then advances by the modifier. The write appears on the memory port one cycle after the grant that completes the word.
- R6: With pack code 0 (16-bit), every bus word produces one internal write, and bits 47:16 are zero.
- R7: With pack code 1 (32-bit) or code 2 or 3 (48-bit), bus words fill the internal word from bit 0 upward in 16-bit steps. The write is issued after 2 or 3 words respectively.
- R8: When the count reaches zero with a partly filled word, that word is written at once, and its unfilled upper bits are zero.
- R9: A channel's interrupt pulses high for one cycle, in the same cycle as the write of the transfer's last word.
- R10: A finished transfer with a zero link pointer stops the channel. A non-zero pointer P causes reads of addresses P, P+1, P+2 and P+3, one per cycle, with data returned one cycle after each read. These words load, in that order, the next link pointer, the address, the modifier and the count. The channel then resumes.
- R11: While a channel is disabled, its request causes no grant, no write and no change to its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_req_i | input | NUM_CH | Per-channel data request (edge for paced channels, level otherwise) |
| ch_data_i | input | NUM_CH*BW | Per-channel bus word, channel c at bits c*BW upward |
| ch_gnt_o | output | NUM_CH | One-cycle grant; the bus word is taken at the next edge |
| irq_o | output | NUM_CH | Transfer-complete pulse per channel |
| cfg_we_i | input | 1 | Load the setup fields into channel cfg_ch_i |
| cfg_ch_i | input | IW | Channel selected for setup |
| cfg_idx_i | input | AW | Start address |
| cfg_mod_i | input | AW | Address step per internal word |
| cfg_cnt_i | input | CW | Bus-word count |
| cfg_next_i | input | AW | Link pointer, zero for none |
| cfg_pack_i | input | 2 | Packing code: 0 = 16, 1 = 32, 2/3 = 48 bit |
| mem_we_o | output | 1 | Internal memory write strobe |
| mem_addr_o | output | AW | Write address |
| mem_wdata_o | output | 3*BW | Packed write data |
| desc_rd_o | output | 1 | Descriptor read strobe |
| desc_addr_o | output | AW | Descriptor read address |
| desc_rdata_i | input | AW | Descriptor read data, valid one cycle after the read |

## Verification
A wrong fill counter in a channel shows up on the memory port within the packing ratio's number of grants: a write arrives early or late, or its data sits in the wrong 16-bit lane. A count or address register that goes wrong shows up as a wrong address on the next write, or as an interrupt that arrives too early or too late relative to the grant sequence. Errors in the descriptor fetcher show up within six cycles of the interrupt, as a wrong read address or as a resumed transfer at a wrong address. Pacing errors show up as extra or missing grants, counted over a held request level.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int unsigned DESC_WORDS = 4;

  // descriptor word order; count last so a channel wakes only when fully loaded
  typedef enum logic [1:0] {
    FLD_NEXT = 2'd0,
    FLD_IDX  = 2'd1,
    FLD_MOD  = 2'd2,
    FLD_CNT  = 2'd3
  } desc_fld_e;

  function automatic logic [1:0] pack_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/dma_prio_arb.sv
`timescale 1ns/1ps
module dma_prio_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        idx_o = IW'(i);
        found = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan import dma_pkg::*; #(
  parameter int unsigned AW    = 20,
  parameter int unsigned CW    = 16,
  parameter int unsigned BW    = 16,
  parameter bit          PACED = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            req_i,
  input  logic [BW-1:0]   bus_data_i,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_idx_i,
  input  logic [AW-1:0]   cfg_mod_i,
  input  logic [CW-1:0]   cfg_cnt_i,
  input  logic [AW-1:0]   cfg_next_i,
  input  logic [1:0]      cfg_pack_i,
  input  logic            svc_i,
  input  logic            ld_we_i,
  input  desc_fld_e       ld_fld_i,
  input  logic [AW-1:0]   ld_data_i,
  output logic            ready_o,
  output logic            wr_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [3*BW-1:0] wr_data_o,
  output logic            done_o,
  output logic [AW-1:0]   next_o
);
  localparam int unsigned WW = 3 * BW;

  logic [AW-1:0] idx_q, mod_q, next_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    pack_q, fill_q, ratio;
  logic [WW-1:0] acc_q, acc_new;
  logic          want, full, last;

  assign ratio   = pack_ratio(pack_q);
  assign acc_new = acc_q | (WW'(bus_data_i) << (fill_q * BW));
  assign full    = (fill_q + 2'd1) == ratio;
  assign last    = cnt_q == CW'(1);

  generate
    if (PACED) begin : g_paced
      logic req_q, pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          req_q  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          req_q  <= req_i;
          pend_q <= (pend_q && !svc_i) || (req_i && !req_q);
        end
      end
      assign want = pend_q;
    end else begin : g_level
      assign want = req_i;
    end
  endgenerate

  assign ready_o   = en_i && (cnt_q != '0) && want;
  assign wr_o      = svc_i && (full || last);
  assign done_o    = svc_i && last;
  assign wr_addr_o = idx_q;
  assign wr_data_o = acc_new;
  assign next_o    = next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mod_q  <= '0;
      next_q <= '0;
      cnt_q  <= '0;
      pack_q <= '0;
      fill_q <= '0;
      acc_q  <= '0;
    end else if (cfg_we_i) begin
      idx_q  <= cfg_idx_i;
      mod_q  <= cfg_mod_i;
      next_q <= cfg_next_i;
      cnt_q  <= cfg_cnt_i;
      pack_q <= cfg_pack_i;
      fill_q <= '0;
      acc_q  <= '0;
    end else if (ld_we_i) begin
      case (ld_fld_i)
        FLD_NEXT: begin
          next_q <= ld_data_i;
          fill_q <= '0;
          acc_q  <= '0;
        end
        FLD_IDX: idx_q <= ld_data_i;
        FLD_MOD: mod_q <= ld_data_i;
        FLD_CNT: cnt_q <= ld_data_i[CW-1:0];
        default: ;
      endcase
    end else if (svc_i) begin
      cnt_q <= cnt_q - CW'(1);
      if (full || last) begin
        acc_q  <= '0;
        fill_q <= '0;
        idx_q  <= idx_q + mod_q;
      end else begin
        acc_q  <= acc_new;
        fill_q <= fill_q + 2'd1;
      end
    end
  end

  AST_SVC_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_i |-> (en_i && cnt_q != '0)); // R4
  AST_FILL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < ratio); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !cfg_we_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !cfg_we_i) |=> (idx_q == $past(idx_q + mod_q))); // R5
endmodule

// File: rtl/dma_desc_fetch.sv
`timescale 1ns/1ps
module dma_desc_fetch import dma_pkg::*; #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 20,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  input  logic [AW-1:0] ptr_i [N],
  output logic          rd_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          ld_we_o,
  output logic [IW-1:0] ld_ch_o,
  output desc_fld_e     ld_fld_o,
  output logic          fin_o
);
  localparam logic [1:0] LAST_W = 2'(DESC_WORDS - 1);

  logic [IW-1:0] pick, ch_q;
  logic          pick_vld, busy_q, iss_q, rv_q;
  logic [AW-1:0] base_q;
  logic [1:0]    rcnt_q;
  desc_fld_e     rf_q;

  dma_prio_arb #(.N(N), .IW(IW)) u_pick (
    .req_i (pend_i),
    .idx_o (pick),
    .any_o (pick_vld)
  );

  assign rd_o      = iss_q;
  assign rd_addr_o = base_q + {{(AW-2){1'b0}}, rcnt_q};
  assign ld_we_o   = rv_q;
  assign ld_ch_o   = ch_q;
  assign ld_fld_o  = rf_q;
  assign fin_o     = rv_q && (rf_q == FLD_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      iss_q  <= 1'b0;
      ch_q   <= '0;
      base_q <= '0;
      rcnt_q <= '0;
      rv_q   <= 1'b0;
      rf_q   <= FLD_NEXT;
    end else begin
      rv_q <= iss_q;
      rf_q <= desc_fld_e'(rcnt_q);
      if (!busy_q) begin
        if (pick_vld) begin
          busy_q <= 1'b1;
          iss_q  <= 1'b1;
          ch_q   <= pick;
          base_q <= ptr_i[pick];
          rcnt_q <= '0;
        end
      end else begin
        if (iss_q) begin
          rcnt_q <= rcnt_q + 2'd1;
          if (rcnt_q == LAST_W) iss_q <= 1'b0;
        end
        if (fin_o) busy_q <= 1'b0;
      end
    end
  end

  AST_LD_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_o |-> $past(rd_o)); // R10
endmodule

// File: rtl/dma_chain_engine.sv
`timescale 1ns/1ps
module dma_chain_engine import dma_pkg::*; #(
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned PACED_CH = 2,
  parameter int unsigned AW       = 20,
  parameter int unsigned CW       = 16,
  parameter int unsigned BW       = 16,
  localparam int unsigned WW      = 3 * BW,
  localparam int unsigned IW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    ch_en_i,
  input  logic [NUM_CH-1:0]    ch_req_i,
  input  logic [NUM_CH*BW-1:0] ch_data_i,
  output logic [NUM_CH-1:0]    ch_gnt_o,
  output logic [NUM_CH-1:0]    irq_o,
  input  logic                 cfg_we_i,
  input  logic [IW-1:0]        cfg_ch_i,
  input  logic [AW-1:0]        cfg_idx_i,
  input  logic [AW-1:0]        cfg_mod_i,
  input  logic [CW-1:0]        cfg_cnt_i,
  input  logic [AW-1:0]        cfg_next_i,
  input  logic [1:0]           cfg_pack_i,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [WW-1:0]        mem_wdata_o,
  output logic                 desc_rd_o,
  output logic [AW-1:0]        desc_addr_o,
  input  logic [AW-1:0]        desc_rdata_i
);
  logic [NUM_CH-1:0] ready, svc, wr, done, fin_vec, chain_set, fpend_q;
  logic [AW-1:0]     wr_addr [NUM_CH];
  logic [WW-1:0]     wr_data [NUM_CH];
  logic [AW-1:0]     nxt     [NUM_CH];
  logic [IW-1:0]     sel_idx, ld_ch;
  logic              sel_vld, ld_we, fin;
  desc_fld_e         ld_fld;

  dma_prio_arb #(.N(NUM_CH), .IW(IW)) u_arb (
    .req_i (ready),
    .idx_o (sel_idx),
    .any_o (sel_vld)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign svc[c]       = sel_vld && (sel_idx == IW'(c));
    assign fin_vec[c]   = fin && (ld_ch == IW'(c));
    assign chain_set[c] = done[c] && (nxt[c] != '0);

    dma_chan #(.AW(AW), .CW(CW), .BW(BW), .PACED(c < PACED_CH)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ch_en_i[c]),
      .req_i      (ch_req_i[c]),
      .bus_data_i (ch_data_i[c*BW +: BW]),
      .cfg_we_i   (cfg_we_i && (cfg_ch_i == IW'(c))),
      .cfg_idx_i  (cfg_idx_i),
      .cfg_mod_i  (cfg_mod_i),
      .cfg_cnt_i  (cfg_cnt_i),
      .cfg_next_i (cfg_next_i),
      .cfg_pack_i (cfg_pack_i),
      .svc_i      (svc[c]),
      .ld_we_i    (ld_we && (ld_ch == IW'(c))),
      .ld_fld_i   (ld_fld),
      .ld_data_i  (desc_rdata_i),
      .ready_o    (ready[c]),
      .wr_o       (wr[c]),
      .wr_addr_o  (wr_addr[c]),
      .wr_data_o  (wr_data[c]),
      .done_o     (done[c]),
      .next_o     (nxt[c])
    );

    AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |=> !irq_o[c]); // R9
    if (c > 0) begin : g_prio
      localparam logic [NUM_CH-1:0] LOW_M = NUM_CH'((1 << c) - 1);
      AST_PRIO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_gnt_o[c] |-> ((ready & LOW_M) == '0)); // R2
    end
  end

  dma_desc_fetch #(.N(NUM_CH), .AW(AW), .IW(IW)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (fpend_q),
    .ptr_i     (nxt),
    .rd_o      (desc_rd_o),
    .rd_addr_o (desc_addr_o),
    .ld_we_o   (ld_we),
    .ld_ch_o   (ld_ch),
    .ld_fld_o  (ld_fld),
    .fin_o     (fin)
  );

  assign ch_gnt_o = svc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      irq_o       <= '0;
      fpend_q     <= '0;
    end else begin
      mem_we_o <= |wr;
      if (|wr) begin
        mem_addr_o  <= wr_addr[sel_idx];
        mem_wdata_o <= wr_data[sel_idx];
      end
      irq_o   <= done;
      fpend_q <= (fpend_q & ~fin_vec) | chain_set;
    end
  end

  AST_MEM_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(|ch_gnt_o)); // R5
endmodule

// File: tb/dma_chain_engine_tb_top.sv
`timescale 1ns/1ps
module dma_chain_engine_tb_top;
  localparam int NCH = 10, AW = 20, CW = 16, BW = 16, WW = 48, IW = 4;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0]    en = '0, req = '0, gnt, irq;
  logic [NCH*BW-1:0] cdata = '0;
  logic              cfg_we = 1'b0;
  logic [IW-1:0]     cfg_ch = '0;
  logic [AW-1:0]     cfg_idx = '0, cfg_mod = '0, cfg_next = '0;
  logic [CW-1:0]     cfg_cnt = '0;
  logic [1:0]        cfg_pack = '0;
  logic              mem_we, desc_rd;
  logic [AW-1:0]     mem_addr, desc_addr, desc_rdata = '0;
  logic [WW-1:0]     mem_wdata;
  logic [AW-1:0]     dmem [16];

  int n_chk = 0, n_fail = 0, wr_n = 0, dr_n = 0, multi = 0;
  int gc [NCH];
  int ic [NCH];
  logic [AW-1:0] wa [16];
  logic [WW-1:0] wd [16];
  logic [AW-1:0] da [16];
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chain_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ch_en_i(en), .ch_req_i(req), .ch_data_i(cdata),
    .ch_gnt_o(gnt), .irq_o(irq), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_idx_i(cfg_idx), .cfg_mod_i(cfg_mod), .cfg_cnt_i(cfg_cnt),
    .cfg_next_i(cfg_next), .cfg_pack_i(cfg_pack), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .desc_rd_o(desc_rd),
    .desc_addr_o(desc_addr), .desc_rdata_i(desc_rdata)
  );

  always @(posedge clk) if (desc_rd) desc_rdata <= dmem[desc_addr[3:0]];

  always @(negedge clk) begin
    if (mem_we) begin
      if (wr_n < 16) begin wa[wr_n] = mem_addr; wd[wr_n] = mem_wdata; end
      wr_n++;
    end
    if (desc_rd) begin
      if (dr_n < 16) da[dr_n] = desc_addr;
      dr_n++;
    end
    for (int c = 0; c < NCH; c++) begin
      gc[c] += int'(gnt[c]);
      ic[c] += int'(irq[c]);
    end
    if ($countones(gnt) > 1) multi++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clr();
    wr_n = 0; dr_n = 0;
    for (int c = 0; c < NCH; c++) begin gc[c] = 0; ic[c] = 0; end
  endtask

  task automatic cfg(input int c, input int idx, input int md, input int cnt, input int nx, input int pk);
    cfg_ch = IW'(c); cfg_idx = AW'(idx); cfg_mod = AW'(md); cfg_cnt = CW'(cnt);
    cfg_next = AW'(nx); cfg_pack = 2'(pk); cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic setd(input int c, input int v);
    cdata[c*BW +: BW] = BW'(v);
  endtask

  // level channel: request held high for n cycles with data base+k
  task automatic run_level(input int c, input int n, input int base);
    en[c] = 1'b1; req[c] = 1'b1;
    for (int k = 0; k < n; k++) begin setd(c, base + k); step(); end
    req[c] = 1'b0; en[c] = 1'b0;
    repeat (3) step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(gnt == '0, "R1 gnt", 64'(gnt), 0);
    chk(irq == '0, "R1 irq", 64'(irq), 0);
    chk(!mem_we, "R1 mem_we", 64'(mem_we), 0);
    chk(!desc_rd, "R1 desc_rd", 64'(desc_rd), 0);
  endtask

  task automatic t_pack16();
    clr();
    cfg(5, 'h100, 2, 3, 0, 0);
    run_level(5, 6, 'hA000);
    chk(gc[5] == 3, "R3 grants", 64'(gc[5]), 3);
    chk(wr_n == 3, "R6 writes", 64'(wr_n), 3);
    for (int k = 0; k < 3; k++) begin
      chk(wa[k] == AW'('h100 + 2*k), "R5 addr", 64'(wa[k]), 64'('h100 + 2*k));
      chk(wd[k] == WW'('hA000 + k), "R6 data", 64'(wd[k]), 64'('hA000 + k));
    end
    chk(ic[5] == 1, "R9 irq", 64'(ic[5]), 1);
    chk(dr_n == 0, "R10 zero link", 64'(dr_n), 0);
  endtask

  task automatic t_pack48();
    clr();
    cfg(6, 'h200, 1, 5, 0, 2);
    run_level(6, 7, 'hB000);
    chk(wr_n == 2, "R7 writes48", 64'(wr_n), 2);
    chk(wa[0] == 'h200 && wa[1] == 'h201, "R5 addr48", 64'(wa[1]), 'h201);
    chk(wd[0] == 48'hB002_B001_B000, "R7 data48", 64'(wd[0]), 48'hB002_B001_B000);
    chk(wd[1] == 48'h0000_B004_B003, "R8 flush", 64'(wd[1]), 48'h0000_B004_B003);
    chk(ic[6] == 1, "R9 irq48", 64'(ic[6]), 1);
  endtask

  task automatic t_pack32();
    clr();
    cfg(7, 'h300, 4, 4, 0, 1);
    run_level(7, 6, 'hC000);
    chk(wr_n == 2, "R7 writes32", 64'(wr_n), 2);
    chk(wa[1] == 'h304, "R5 addr32", 64'(wa[1]), 'h304);
    chk(wd[0] == 48'h0000_C001_C000, "R7 data32a", 64'(wd[0]), 48'h0000_C001_C000);
    chk(wd[1] == 48'h0000_C003_C002, "R7 data32b", 64'(wd[1]), 48'h0000_C003_C002);
  endtask

  task automatic t_priority();
    clr();
    cfg(3, 'h400, 1, 2, 0, 0);
    cfg(8, 'h500, 1, 2, 0, 0);
    en[3] = 1'b1; en[8] = 1'b1; req[3] = 1'b1; req[8] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      setd(3, 'hD300 + k); setd(8, 'hD800 + k); step();
    end
    req[3] = 1'b0; req[8] = 1'b0; en[3] = 1'b0; en[8] = 1'b0;
    repeat (3) step();
    chk(wr_n == 4, "R2 writes", 64'(wr_n), 4);
    chk(wa[0] == 'h400 && wa[1] == 'h401, "R2 low first", 64'(wa[1]), 'h401);
    chk(wa[2] == 'h500 && wa[3] == 'h501, "R2 high after", 64'(wa[2]), 'h500);
    chk(wd[2] == WW'('hD802), "R2 data", 64'(wd[2]), 'hD802);
    chk(multi == 0, "R2 onehot", 64'(multi), 0);
  endtask

  task automatic t_paced();
    clr();
    cfg(0, 'h10, 1, 2, 0, 0);
    setd(0, 'hE000);
    req[0] = 1'b1; step(); req[0] = 1'b0;
    repeat (4) step();
    chk(gc[0] == 0 && wr_n == 0, "R4 disabled hold", 64'(gc[0]), 0);
    en[0] = 1'b1;
    repeat (3) step();
    chk(gc[0] == 1, "R4 held edge", 64'(gc[0]), 1);
    req[0] = 1'b1; repeat (5) step(); req[0] = 1'b0;
    repeat (2) step();
    chk(gc[0] == 2, "R4 level once", 64'(gc[0]), 2);
    chk(ic[0] == 1, "R9 paced irq", 64'(ic[0]), 1);
    req[0] = 1'b1; step(); req[0] = 1'b0;
    repeat (3) step();
    chk(gc[0] == 2 && wr_n == 2, "R4 count zero", 64'(gc[0]), 2);
    en[0] = 1'b0;
  endtask

  task automatic t_disabled();
    clr();
    cfg(9, 'h900, 1, 2, 0, 0);
    req[9] = 1'b1;
    for (int k = 0; k < 6; k++) begin setd(9, 'hF000 + k); step(); end
    chk(gc[9] == 0 && wr_n == 0, "R11 no grant", 64'(gc[9]), 0);
    en[9] = 1'b1;
    repeat (4) step();
    req[9] = 1'b0; en[9] = 1'b0;
    repeat (2) step();
    chk(gc[9] == 2 && wr_n == 2, "R11 count kept", 64'(gc[9]), 2);
    chk(wa[0] == 'h900 && wa[1] == 'h901, "R11 addr kept", 64'(wa[1]), 'h901);
  endtask

  task automatic t_chain();
    clr();
    dmem[8] = '0; dmem[9] = 'h700; dmem[10] = 3; dmem[11] = 2;
    cfg(4, 'h600, 1, 1, 8, 0);
    run_level(4, 14, 'h7700);
    chk(dr_n == 4, "R10 reads", 64'(dr_n), 4);
    chk(da[0] == 8 && da[3] == 11, "R10 read addr", 64'(da[3]), 11);
    chk(wr_n == 3, "R10 writes", 64'(wr_n), 3);
    chk(wa[0] == 'h600, "R10 first addr", 64'(wa[0]), 'h600);
    chk(wa[1] == 'h700 && wa[2] == 'h703, "R10 reload addr", 64'(wa[2]), 'h703);
    chk(ic[4] == 2, "R9 chain irq", 64'(ic[4]), 2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    for (int c = 0; c < NCH; c++) begin gc[c] = 0; ic[c] = 0; end
    t_reset();
    t_pack16();
    t_pack48();
    t_pack32();
    t_priority();
    t_paced();
    t_disabled();
    t_chain();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule